// File: doc/BRIEF.md
# PIO Memory Window Lock Controller

This block sits between a CPU's programmed-I/O request port and a PCI master engine. Any CPU access whose address lands in a fixed 16 MB window becomes a 32-bit PCI memory-cycle request. The low 24 address bits come from the CPU. The top 8 bits come from a base register that software rewrites whenever it needs to reach a different 16 MB region. The window is decoded at two places: the primary range 0xFD000000–0xFDFFFFFF and an alias at 0x1D000000–0x1DFFFFFF.

The block also sequences locked read-modify-write operations. When the base register's lock bit is set, window accesses go out as locked PCI transfers. A locked read establishes the lock and records the 16-byte block it targeted. The next locked write releases the lock. While the lock is held, unlocked window requests are completed to the CPU without touching the bus, and DMA requests are not granted.

The CPU and PCI request ports are valid/ready. The CPU side is ready only while no request is in flight. A PCI request stays valid, with all fields unchanged, until the PCI engine accepts it. The engine then signals completion with a one-cycle done pulse. The base register, DMA handshake and status pins are plain levels.

Top module: `pio_lock_bridge`

## Requirements
- R1: A CPU request is in the window when address bits [31:24] equal 0xFD or 0x1D, and both ranges behave identically. A request outside the window is accepted on the handshake and then dropped: it produces no PCI request and no cpu_ack.
- R2: For a window request, pci_addr[31:24] equals the base field and pci_addr[23:2] equals cpu_addr[23:2].
- R3: pci_addr[1:0] is always 00 while pci_req_valid is high, whatever the CPU's low address bits are.
- R4: pci_lock carries the base register's lock bit and pci_write carries cpu_write. A base register write (cfg_wr) applies to the next request accepted after it.
- R5: When a locked read completes (its pci_done), lock_held goes to 1 from the next cycle, and lock_addr holds that read's PCI address bits [31:4].
- R6: A locked write issued while lock_held is 0 is sent to PCI and acknowledged normally, and it leaves lock_held at 0.
- R7: While the lock is held, a further locked read is sent to PCI and keeps the lock, with lock_addr updated to its block. A locked write is sent to PCI, including one aimed at a different address, and its pci_done clears lock_held.
- R8: While the lock is held, an unlocked window request raises no pci_req_valid. cpu_ack is asserted in the cycle after acceptance.
- R9: dma_grant equals dma_req while lock_held is 0 and stays low while it is 1. It returns the cycle after the releasing write's pci_done.
- R10: pci_req_valid stays high with pci_addr, pci_lock and pci_write stable until pci_req_ready is seen. For a forwarded request, cpu_ack is asserted in the same cycle as pci_done.
- R11: After synchronous reset: base field 0, lock bit 0, lock_held 0, pci_req_valid 0, cpu_req_ready 1.
- R12: Each window request is acknowledged exactly once, with cpu_ack high for a single cycle. cpu_req_ready stays low from acceptance until the cycle after cpu_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Base register write strobe |
| cfg_base | input | 8 | Upper PCI address field to write |
| cfg_lock | input | 1 | Lock bit to write |
| cpu_req_valid | input | 1 | CPU request valid |
| cpu_req_ready | output | 1 | Block can accept a CPU request |
| cpu_addr | input | 32 | CPU address |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_ack | output | 1 | One-cycle completion of a window request |
| pci_req_valid | output | 1 | PCI memory-cycle request valid |
| pci_req_ready | input | 1 | PCI engine takes the request |
| pci_addr | output | 32 | PCI memory address |
| pci_lock | output | 1 | Request is a locked transfer |
| pci_write | output | 1 | Request direction, 1 = write |
| pci_done | input | 1 | One-cycle completion from PCI engine |
| dma_req | input | 1 | DMA engine requests the bus |
| dma_grant | output | 1 | DMA grant |
| lock_held | output | 1 | Lock currently established |
| lock_addr | output | 28 | Locked 16-byte block, address bits [31:4] |

## Verification
The hardest state to reach from the ports is a held lock meeting a mixed stream of traffic. That means unlocked requests that must vanish from the bus, locked writes to foreign addresses, repeated locked reads, and back-pressure on the PCI side, all arriving while a DMA request waits. To get there, the random stimulus flips the base register's lock bit often and spreads addresses over both window ranges and the outside region. Directed sequences first build the read-read-write and write-without-lock cases and hold pci_req_ready low for several cycles. A bench model tracks the lock state and the recorded block, and every access is compared against it.

// File: rtl/pio_lock_pkg.sv
package pio_lock_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_SUPP  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/pio_win_decode.sv
module pio_win_decode #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 24,
  parameter logic [ADDR_W-OFS_W-1:0] WIN_TAG   = 8'hFD,
  parameter logic [ADDR_W-OFS_W-1:0] ALIAS_TAG = 8'h1D,
  localparam int TAG_W = ADDR_W - OFS_W
) (
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [TAG_W-1:0]  base,
  output logic              hit,
  output logic [ADDR_W-1:0] pci_addr
);
  logic [TAG_W-1:0] tag;
  assign tag = cpu_addr[ADDR_W-1:OFS_W];
  assign hit = (tag == WIN_TAG) || (tag == ALIAS_TAG);
  // memory cycles force the two byte-lane bits to zero
  assign pci_addr = {base, cpu_addr[OFS_W-1:2], 2'b00};
endmodule

// File: rtl/pio_lock_seq.sv
module pio_lock_seq
  import pio_lock_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BLK_LSB = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cpu_req_valid,
  output logic                      cpu_req_ready,
  input  logic                      cpu_write,
  input  logic                      win_hit,
  input  logic [ADDR_W-1:0]         win_addr,
  input  logic                      lock_bit,
  output logic                      cpu_ack,
  output logic                      pci_req_valid,
  input  logic                      pci_req_ready,
  output logic [ADDR_W-1:0]         pci_addr,
  output logic                      pci_lock,
  output logic                      pci_write,
  input  logic                      pci_done,
  input  logic                      dma_req,
  output logic                      dma_grant,
  output logic                      lock_held,
  output logic [ADDR_W-BLK_LSB-1:0] lock_addr
);
  seq_state_e state;
  logic accept;

  assign cpu_req_ready = (state == ST_IDLE);
  assign accept        = cpu_req_valid && cpu_req_ready && win_hit;
  assign pci_req_valid = (state == ST_ISSUE);
  assign cpu_ack       = (state == ST_SUPP) || ((state == ST_WAIT) && pci_done);
  assign dma_grant     = dma_req && !lock_held;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pci_addr  <= '0;
      pci_lock  <= 1'b0;
      pci_write <= 1'b0;
      lock_held <= 1'b0;
      lock_addr <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          pci_addr  <= win_addr;
          pci_lock  <= lock_bit;
          pci_write <= cpu_write;
          state     <= (lock_held && !lock_bit) ? ST_SUPP : ST_ISSUE;
        end
        ST_ISSUE: if (pci_req_ready) state <= ST_WAIT;
        ST_WAIT: if (pci_done) begin
          state <= ST_IDLE;
          if (pci_lock && !pci_write) begin
            lock_held <= 1'b1;
            lock_addr <= pci_addr[ADDR_W-1:BLK_LSB];
          end else if (pci_lock && pci_write) begin
            lock_held <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    pci_req_valid && !pci_req_ready |=> pci_req_valid && $stable(pci_addr)
      && $stable(pci_lock) && $stable(pci_write));
  // R12
  single_ack_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |=> !cpu_ack);
  // R5
  lock_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_held) |-> $past(pci_done && pci_lock && !pci_write));
  // R7
  lock_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_held) |-> $past(pci_done && pci_lock && pci_write));
  // R8
  supp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SUPP) |-> !pci_req_valid && $past(accept));
endmodule

// File: rtl/pio_lock_bridge.sv
module pio_lock_bridge #(
  parameter int ADDR_W  = 32,
  parameter int OFS_W   = 24,
  parameter int BLK_LSB = 4,
  localparam int TAG_W  = ADDR_W - OFS_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_wr,
  input  logic [TAG_W-1:0]          cfg_base,
  input  logic                      cfg_lock,
  input  logic                      cpu_req_valid,
  output logic                      cpu_req_ready,
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic                      cpu_write,
  output logic                      cpu_ack,
  output logic                      pci_req_valid,
  input  logic                      pci_req_ready,
  output logic [ADDR_W-1:0]         pci_addr,
  output logic                      pci_lock,
  output logic                      pci_write,
  input  logic                      pci_done,
  input  logic                      dma_req,
  output logic                      dma_grant,
  output logic                      lock_held,
  output logic [ADDR_W-BLK_LSB-1:0] lock_addr
);
  logic [TAG_W-1:0]  base_q;
  logic              lock_q;
  logic              hit;
  logic [ADDR_W-1:0] win_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      lock_q <= 1'b0;
    end else if (cfg_wr) begin
      base_q <= cfg_base;
      lock_q <= cfg_lock;
    end
  end

  pio_win_decode #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_dec (
    .cpu_addr (cpu_addr),
    .base     (base_q),
    .hit      (hit),
    .pci_addr (win_addr)
  );

  pio_lock_seq #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB)) u_seq (
    .clk           (clk),
    .rst           (rst),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_ready (cpu_req_ready),
    .cpu_write     (cpu_write),
    .win_hit       (hit),
    .win_addr      (win_addr),
    .lock_bit      (lock_q),
    .cpu_ack       (cpu_ack),
    .pci_req_valid (pci_req_valid),
    .pci_req_ready (pci_req_ready),
    .pci_addr      (pci_addr),
    .pci_lock      (pci_lock),
    .pci_write     (pci_write),
    .pci_done      (pci_done),
    .dma_req       (dma_req),
    .dma_grant     (dma_grant),
    .lock_held     (lock_held),
    .lock_addr     (lock_addr)
  );

  // R3
  lane_zero_chk: assert property (@(posedge clk) disable iff (rst)
    pci_req_valid |-> pci_addr[1:0] == 2'b00);
  // R9
  dma_hold_chk: assert property (@(posedge clk) disable iff (rst)
    lock_held && dma_req |=> !dma_grant || $past(pci_done));
endmodule

// File: tb/pio_lock_bridge_test.sv
module pio_lock_bridge_test;
  logic clk = 1'b0;
  logic rst;
  logic cfg_wr, cfg_lock;
  logic [7:0] cfg_base;
  logic cpu_req_valid, cpu_req_ready, cpu_write, cpu_ack;
  logic [31:0] cpu_addr, pci_addr;
  logic pci_req_valid, pci_req_ready, pci_lock, pci_write, pci_done;
  logic dma_req, dma_grant, lock_held;
  logic [27:0] lock_addr;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_base;
  logic m_lockbit, m_held;
  logic [27:0] m_laddr;

  always #10 clk = ~clk;

  pio_lock_bridge uut (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_pci(logic [7:0] b, logic [31:0] a);
    return {b, a[23:2], 2'b00};
  endfunction

  function automatic logic in_win(logic [31:0] a);
    return a[31:24] == 8'hFD || a[31:24] == 8'h1D;
  endfunction

  task automatic set_base(logic [7:0] b, logic lk);
    @(negedge clk);
    cfg_wr = 1; cfg_base = b; cfg_lock = lk;
    @(negedge clk);
    cfg_wr = 0;
    m_base = b; m_lockbit = lk;
  endtask

  task automatic access(logic [31:0] a, logic wr, int stall);
    logic issue;
    @(negedge clk);
    check("R12 ready idle", cpu_req_ready, 1);
    check("R9 dma", dma_grant, !m_held);
    cpu_req_valid = 1; cpu_addr = a; cpu_write = wr;
    @(negedge clk);
    cpu_req_valid = 0;
    if (!in_win(a)) begin
      for (int i = 0; i < 3; i++) begin
        check("R1 miss no req", pci_req_valid, 0);
        check("R1 miss no ack", cpu_ack, 0);
        @(negedge clk);
      end
      return;
    end
    check("R12 busy", cpu_req_ready, 0);
    issue = !(m_held && !m_lockbit);
    if (!issue) begin
      check("R8 suppressed ack", cpu_ack, 1);
      check("R8 no pci req", pci_req_valid, 0);
      @(negedge clk);
      check("R12 single ack", cpu_ack, 0);
      check("R8 lock kept", lock_held, 1);
      return;
    end
    check("R10 req valid", pci_req_valid, 1);
    check("R2 addr", pci_addr, exp_pci(m_base, a));
    check("R3 lanes", pci_addr[1:0], 0);
    check("R4 lock flag", pci_lock, m_lockbit);
    check("R4 dir", pci_write, wr);
    if (stall > 0) begin
      pci_req_ready = 0;
      for (int i = 0; i < stall; i++) begin
        @(negedge clk);
        check("R10 hold valid", pci_req_valid, 1);
        check("R10 hold addr", pci_addr, exp_pci(m_base, a));
        check("R10 no early ack", cpu_ack, 0);
      end
      pci_req_ready = 1;
    end
    @(negedge clk);
    check("R10 valid drop", pci_req_valid, 0);
    check("R10 no ack before done", cpu_ack, 0);
    pci_done = 1;
    #1 check("R10 ack with done", cpu_ack, 1);
    @(negedge clk);
    pci_done = 0;
    check("R12 single ack", cpu_ack, 0);
    if (m_lockbit && !wr) begin
      m_held = 1; m_laddr = exp_pci(m_base, a) >> 4;
    end else if (m_lockbit && wr) m_held = 0;
    check("R5 R7 lock_held", lock_held, m_held);
    check("R9 dma after", dma_grant, !m_held);
    if (m_held) check("R5 lock_addr", lock_addr, m_laddr);
  endtask

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    rst = 1; cfg_wr = 0; cfg_base = 0; cfg_lock = 0;
    cpu_req_valid = 0; cpu_addr = 0; cpu_write = 0;
    pci_req_ready = 1; pci_done = 0; dma_req = 1;
    m_base = 0; m_lockbit = 0; m_held = 0; m_laddr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    check("R11 lock_held", lock_held, 0);
    check("R11 pci valid", pci_req_valid, 0);
    check("R11 ready", cpu_req_ready, 1);
    check("R9 dma idle", dma_grant, 1);
    // R1 R2 R3 both ranges, base zero then rewritten
    access(32'hFD12_3457, 0, 0);
    set_base(8'hA5, 0);
    access(32'h1D12_3456, 1, 2);
    access(32'h4000_0000, 0, 0);
    // R6 locked write with no lock
    set_base(8'h33, 1);
    access(32'hFD00_0103, 1, 0);
    // R5 R7 read, second read, foreign write
    access(32'hFD00_0100, 0, 1);
    access(32'h1D00_0208, 0, 0);
    set_base(8'h33, 0);
    access(32'hFD00_0300, 1, 0); // R8 suppressed
    access(32'hFD00_0304, 0, 0); // R8 suppressed
    set_base(8'h77, 1);
    access(32'h1DFF_FFF0, 1, 3); // R7 release
    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [31:0] a;
      int r = $urandom % 4;
      a = $urandom;
      if (r == 0) a[31:24] = 8'hFD;
      else if (r == 1) a[31:24] = 8'h1D;
      else if (r == 2 && a[31:24] != 8'hFD && a[31:24] != 8'h1D) a[31:24] = a[31:24];
      else a[31:24] = 8'hFD;
      if ($urandom % 5 == 0) set_base(8'($urandom), 1'($urandom));
      access(a, 1'($urandom), int'($urandom % 3));
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule